// File: doc/BRIEF.md
# Self-Synchronizing Chaotic Masking Link

This block holds both ends of a chaotic masking link. The transmit end runs a three-variable nonlinear map in signed fixed point. Each time a plaintext bit arrives, it adds the bit (as 0 or 1.0) to the map's y state. The result is a 32-bit cipher sample, and the map then iterates with that sample as its drive term. The receive end runs an identical map and drives it with the received cipher sample. It subtracts its own y state from the sample to recover the bit value, then makes a registered hard decision against a small threshold.

Both maps iterate on the transmitted sample rather than on a private state. Because of this, the receiver tracks the transmitter exactly, provided both start from the same reset state and round their products identically. The keystream is added arithmetically, not XORed, so the recovered value is exact under 32-bit wrap-around. The two ends have independent strobes and can be wired together directly or through any lossless channel.

All quantities use a signed format with 20 fractional bits (1.0 = 1048576). Products are formed at 64-bit width, shifted right arithmetically by 20 and truncated to 32 bits.

Top module: `chaos_mask_link`

## Requirements
- R1: A tx_valid pulse with tx_bit registers tx_cipher = tx_bit·1048576 + y (the current transmit y state), with tx_cipher_valid high in the following cycle.
- R2: Reset (rst_n low) loads x = 1049, y = 2097 and z = 20972 (0.001, 0.002 and 0.02 with 20 fractional bits) into both maps, and clears every output to zero.
- R3: Each step applies y' = 0.028x − 0.001(xz) + 0.999s, x' = 0.99x + 0.01s and z' = 0.001(xs) + 0.9973333z. The coefficients are 29360, 1049, 1047527, 1038090, 10486, 1049 and 1045780. Each product is computed as (a·b at 64 bits) >>> 20, truncated to 32 bits, and s is the current cipher sample.
- R4: The first step after reset on each side uses that side's own y in place of s. The second cipher sample therefore does not depend on the first plaintext bit.
- R5: With its strobe low, a side holds its map state and its registered outputs. Inserting idle cycles between bits leaves the cipher sequence unchanged.
- R6: An rx_valid pulse registers rx_value = rx_cipher − y (the current receive y state), with rx_value_valid high in the following cycle.
- R7: One cycle after rx_value_valid, rx_bit is 0 if rx_value (signed) is below 255 and 1 otherwise, with rx_bit_valid high.
- R8: With tx_cipher and tx_cipher_valid looped into rx_cipher and rx_valid, every rx_bit equals the bit that was sent, and rx_value equals exactly bit·1048576.
- R9: In loopback, tx_cipher never equals the bare bit value bit·1048576.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Transmit strobe, one per plaintext bit |
| tx_bit | input | 1 | Plaintext bit |
| tx_cipher | output | 32 | Cipher sample, signed, 20 fractional bits |
| tx_cipher_valid | output | 1 | tx_cipher is new this cycle |
| rx_valid | input | 1 | Receive strobe, one per received sample |
| rx_cipher | input | 32 | Received cipher sample, signed |
| rx_value | output | 32 | Recovered value, signed |
| rx_value_valid | output | 1 | rx_value is new this cycle |
| rx_bit | output | 1 | Recovered bit decision |
| rx_bit_valid | output | 1 | rx_bit is new this cycle |

## Verification
The threshold is probed from a freshly reset receiver at 254, 255, 256 and at negative values. A comparison that is off by one, or unsigned, would flip the decision at one of these points. The second cipher sample is checked against a value computed from the update equations, and compared between first bits of 0 and 1. A design that ignored the first-step rule, or rounded its products differently, would give a different sample there. A long random loopback with idle gaps would expose any loss of lock-step, such as a state that moves on an idle cycle, a skewed strobe or an asymmetric update, as wrong bits.

// File: rtl/chaos_pkg.sv
package chaos_pkg;
    parameter int unsigned DW   = 32;
    parameter int unsigned FRAC = 20;
    localparam int unsigned PW  = 2 * DW;

    typedef logic signed [DW-1:0] fx_t;

    localparam fx_t FX_ONE = fx_t'(1) <<< FRAC;

    typedef struct packed {
        fx_t  x;
        fx_t  y;
        fx_t  z;
        logic first;
    } map_state_t;

    // full-width product, arithmetic shift by FRAC, truncated to DW bits
    function automatic fx_t fx_mul(input fx_t a, input fx_t b);
        logic signed [PW-1:0] p;
        p = PW'(a) * PW'(b);
        return p[FRAC+DW-1:FRAC];
    endfunction
endpackage

// File: rtl/chaos_map.sv
module chaos_map
    import chaos_pkg::*;
#(
    parameter fx_t K_YX   = 29360,
    parameter fx_t K_YXZ  = 1049,
    parameter fx_t K_YS   = 1047527,
    parameter fx_t K_XX   = 1038090,
    parameter fx_t K_XS   = 10486,
    parameter fx_t K_ZXS  = 1049,
    parameter fx_t K_ZZ   = 1045780,
    parameter fx_t INIT_X = 1049,
    parameter fx_t INIT_Y = 2097,
    parameter fx_t INIT_Z = 20972
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  fx_t  drive,
    output fx_t  y_out
);
    map_state_t st_d, st_q;
    fx_t s_eff, xz, xs;

    always_comb begin
        st_d  = st_q;
        // first step after reset iterates on the map's own y
        s_eff = st_q.first ? st_q.y : drive;
        xz    = fx_mul(st_q.x, st_q.z);
        xs    = fx_mul(st_q.x, s_eff);
        if (step) begin
            st_d.y     = fx_mul(K_YX, st_q.x) - fx_mul(K_YXZ, xz) + fx_mul(K_YS, s_eff);
            st_d.x     = fx_mul(K_XX, st_q.x) + fx_mul(K_XS, s_eff);
            st_d.z     = fx_mul(K_ZXS, xs) + fx_mul(K_ZZ, st_q.z);
            st_d.first = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.x     <= INIT_X;
            st_q.y     <= INIT_Y;
            st_q.z     <= INIT_Z;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_out = st_q.y;
endmodule

// File: rtl/chaos_tx.sv
module chaos_tx
    import chaos_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic plain,
    output fx_t  cipher,
    output logic cipher_valid
);
    typedef struct packed {
        fx_t  cipher;
        logic vld;
    } tx_state_t;

    tx_state_t st_d, st_q;
    fx_t key_y, sample;

    assign sample = plain ? key_y + FX_ONE : key_y;

    chaos_map i_map (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (valid),
        .drive (sample),
        .y_out (key_y)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid;
        if (valid) st_d.cipher = sample;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cipher       = st_q.cipher;
    assign cipher_valid = st_q.vld;
endmodule

// File: rtl/chaos_rx.sv
module chaos_rx
    import chaos_pkg::*;
#(
    parameter fx_t THRESH = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  fx_t  cipher,
    output fx_t  value,
    output logic value_valid,
    output logic dec,
    output logic dec_valid
);
    typedef struct packed {
        fx_t  value;
        logic vvld;
        logic dec;
        logic dvld;
    } rx_state_t;

    rx_state_t st_d, st_q;
    fx_t key_y;

    chaos_map i_map (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (valid),
        .drive (cipher),
        .y_out (key_y)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vvld = valid;
        st_d.dvld = st_q.vvld;
        if (valid)     st_d.value = cipher - key_y;
        if (st_q.vvld) st_d.dec   = (st_q.value >= THRESH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value       = st_q.value;
    assign value_valid = st_q.vvld;
    assign dec         = st_q.dec;
    assign dec_valid   = st_q.dvld;
endmodule

// File: rtl/chaos_mask_link.sv
module chaos_mask_link #(
    parameter int THRESH = 255
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_valid,
    input  logic               tx_bit,
    output logic signed [31:0] tx_cipher,
    output logic               tx_cipher_valid,
    input  logic               rx_valid,
    input  logic signed [31:0] rx_cipher,
    output logic signed [31:0] rx_value,
    output logic               rx_value_valid,
    output logic               rx_bit,
    output logic               rx_bit_valid
);
    chaos_tx i_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid        (tx_valid),
        .plain        (tx_bit),
        .cipher       (tx_cipher),
        .cipher_valid (tx_cipher_valid)
    );

    chaos_rx #(.THRESH(chaos_pkg::fx_t'(THRESH))) i_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid       (rx_valid),
        .cipher      (rx_cipher),
        .value       (rx_value),
        .value_valid (rx_value_valid),
        .dec         (rx_bit),
        .dec_valid   (rx_bit_valid)
    );
endmodule

// File: rtl/chaos_link_checker.sv
module chaos_link_checker (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_valid,
    input logic signed [31:0] tx_cipher,
    input logic               tx_cipher_valid,
    input logic               rx_valid,
    input logic signed [31:0] rx_value,
    input logic               rx_value_valid,
    input logic               rx_bit,
    input logic               rx_bit_valid
);
    a_r1_tx_latency: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> tx_cipher_valid);

    a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> (!tx_cipher_valid && $stable(tx_cipher)));

    a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (!rx_value_valid && $stable(rx_value)));

    a_r6_rx_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_value_valid);

    a_r7_bit_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rx_value_valid |=> rx_bit_valid);

    a_r7_decision: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit_valid |-> (rx_bit == ($past(rx_value) >= 32'sd255)));
endmodule

bind chaos_mask_link chaos_link_checker i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tx_valid        (tx_valid),
    .tx_cipher       (tx_cipher),
    .tx_cipher_valid (tx_cipher_valid),
    .rx_valid        (rx_valid),
    .rx_value        (rx_value),
    .rx_value_valid  (rx_value_valid),
    .rx_bit          (rx_bit),
    .rx_bit_valid    (rx_bit_valid)
);

// File: tb/test_chaos_mask_link.sv
module test_chaos_mask_link;
    localparam int ONE    = 1048576;
    localparam int Y0     = 2097;
    localparam int NRAND  = 10000;
    localparam int NTAB   = 8;

    // receive threshold vectors: offset above initial y, expected decision
    localparam logic signed [31:0] TAB_OFF [NTAB] =
        '{32'sd254, 32'sd255, 32'sd256, -32'sd5, 32'sd0, 32'sd1048576, -32'sd1048576, 32'sd100000};
    localparam logic TAB_EXP [NTAB] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_valid = 1'b0, tx_bit = 1'b0;
    logic drv_rx_valid = 1'b0;
    logic signed [31:0] drv_rx_cipher = '0;
    logic loop_en = 1'b0;
    logic mon_en = 1'b0;
    logic signed [31:0] tx_cipher, rx_value, rx_cipher;
    logic tx_cipher_valid, rx_valid, rx_value_valid, rx_bit, rx_bit_valid;

    int checks = 0, fails = 0;
    logic sent [NRAND];
    int tx_idx = 0, rv_idx = 0, rb_idx = 0;

    assign rx_valid  = loop_en ? tx_cipher_valid : drv_rx_valid;
    assign rx_cipher = loop_en ? tx_cipher : drv_rx_cipher;

    always #5 clk = ~clk;

    chaos_mask_link i_chaos_mask_link (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_bit(tx_bit),
        .tx_cipher(tx_cipher), .tx_cipher_valid(tx_cipher_valid),
        .rx_valid(rx_valid), .rx_cipher(rx_cipher),
        .rx_value(rx_value), .rx_value_valid(rx_value_valid),
        .rx_bit(rx_bit), .rx_bit_valid(rx_bit_valid)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int fxm(input int a, input int b);
        longint p;
        p = longint'(a) * longint'(b);
        return int'(p >>> 20);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tx_valid = 1'b0; drv_rx_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input logic b, input int idle, output int c);
        @(negedge clk);
        tx_valid = 1'b1; tx_bit = b;
        @(negedge clk);
        tx_valid = 1'b0;
        c = tx_cipher;
        for (int k = 0; k < idle; k++) begin
            @(negedge clk);
            chk(tx_cipher == c && !tx_cipher_valid, "R5 tx hold", tx_cipher, c);
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (tx_cipher_valid) begin
                chk(tx_cipher != (sent[tx_idx] ? ONE : 0), "R9 cipher masked", tx_cipher, -1);
                tx_idx++;
            end
            if (rx_value_valid) begin
                chk(rx_value == (sent[rv_idx] ? ONE : 0), "R8 rx_value", rx_value, sent[rv_idx] ? ONE : 0);
                rv_idx++;
            end
            if (rx_bit_valid) begin
                chk(rx_bit == sent[rb_idx], "R8 rx_bit", rx_bit, sent[rb_idx]);
                rb_idx++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int c1, c2a, c2b, y1;
        int ca [8];
        int cb [8];
        logic [7:0] pat;
        pat = 8'b0100_1101;

        // R2: reset state
        do_reset();
        chk(tx_cipher == 0 && !tx_cipher_valid, "R2 tx reset", tx_cipher, 0);
        chk(rx_value == 0 && !rx_value_valid && !rx_bit && !rx_bit_valid, "R2 rx reset", rx_value, 0);

        // receive threshold table (R6, R7)
        for (int i = 0; i < NTAB; i++) begin
            do_reset();
            @(negedge clk);
            drv_rx_valid = 1'b1; drv_rx_cipher = Y0 + TAB_OFF[i];
            @(negedge clk);
            drv_rx_valid = 1'b0;
            chk(rx_value == TAB_OFF[i] && rx_value_valid, "R6 rx_value", rx_value, TAB_OFF[i]);
            @(negedge clk);
            chk(rx_bit == TAB_EXP[i] && rx_bit_valid, "R7 decision", rx_bit, TAB_EXP[i]);
        end

        // R1 first cipher values, R3/R4 second sample
        y1 = fxm(29360, 1049) - fxm(1049, fxm(1049, 20972)) + fxm(1047527, Y0);
        do_reset();
        send_bit(1'b1, 0, c1);
        chk(c1 == ONE + Y0, "R1 cipher bit1", c1, ONE + Y0);
        send_bit(1'b0, 0, c2a);
        chk(c2a == y1, "R3 second sample", c2a, y1);
        do_reset();
        send_bit(1'b0, 0, c1);
        chk(c1 == Y0, "R1 cipher bit0", c1, Y0);
        send_bit(1'b0, 0, c2b);
        chk(c2b == c2a, "R4 first step own y", c2b, c2a);

        // R5: idle gaps do not change the sequence
        do_reset();
        for (int i = 0; i < 8; i++) send_bit(pat[i], 0, ca[i]);
        do_reset();
        for (int i = 0; i < 8; i++) send_bit(pat[i], 3, cb[i]);
        for (int i = 0; i < 8; i++) chk(ca[i] == cb[i], "R5 gap sequence", cb[i], ca[i]);

        // R8/R9: random loopback
        loop_en = 1'b1;
        do_reset();
        mon_en = 1'b1;
        for (int i = 0; i < NRAND; i++) begin
            if ($urandom_range(3) == 0) begin
                @(negedge clk);
                tx_valid = 1'b0;
            end
            @(negedge clk);
            sent[i] = 1'($urandom_range(1));
            tx_valid = 1'b1;
            tx_bit = sent[i];
        end
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (5) @(negedge clk);
        mon_en = 1'b0;
        chk(rb_idx == NRAND, "R8 bit count", rb_idx, NRAND);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule